// File: doc/BRIEF.md
# Endian-Selectable Load/Store Lane Aligner

This block sits between a 32-bit register file and a byte-addressed 32-bit memory bus. For each access it takes the address, the size (byte, halfword or word), the direction, the store operand and a sign-extend flag. It then produces the word-aligned bus address, the byte enables and the write data with each byte placed on its lane. When the bus returns read data, it gathers the accessed bytes into a right-justified, zero- or sign-extended load result.

Byte order is chosen per access by a big-endian input, so consecutive accesses may use different orders with no added cycle. A style input picks how big-endian order is produced. In the lane-swap style, a byte address always names the same memory byte in both orders, and only the order of bytes inside halfword and word values is reversed. In the address-flip style, the low address bits of sub-word accesses are inverted in big-endian mode and the data keeps little-endian lane order. Both styles share one datapath in which every byte lane is a 4:1 multiplexer. The mode and style only change the multiplexer selects, so the delay through the datapath is the same in every mode.

Top module: `lsAlign`

## Requirements
- R1: `busAddr` equals `reqAddr` with its two low bits forced to zero. `reqSize` encodes 0 = byte, 1 = halfword, 2 or 3 = word.
- R2: With `reqValid` high and no misalignment, `busByteEn` has one bit set for a byte access, two adjacent bits starting at an even lane for a halfword, and all four bits for a word. With `reqValid` low, `busByteEn` is zero. Bus lane k carries the byte at word address + k.
- R3: In the lane-swap style (`styleFlip` = 0), the effective byte offset is `reqAddr[1:0]`. A byte access uses lane `reqAddr[1:0]` in both byte orders.
- R4: In the lane-swap style with `bigEnd` = 1, the bytes of a halfword or word are reversed: the most significant byte sits at the lowest address. With `bigEnd` = 0, the least significant byte sits at the lowest address.
- R5: In the address-flip style (`styleFlip` = 1) with `bigEnd` = 1, the offset is `reqAddr[1:0]` XOR 3 for bytes, XOR 2 for halfwords and unchanged for words, and value bytes keep little-endian order from that offset. With `bigEnd` = 0, this style is plain little-endian.
- R6: On a store, every enabled lane of `busWrData` carries the store-operand byte that R3 to R5 map to that lane. Store-operand byte i is `storeData[8i+7:8i]`.
- R7: On a load, the accessed bytes form the low bytes of `loadData`, with value byte 0 in bits 7:0. The upper bytes are zero when `reqSigned` = 0 and copies of the top accessed bit when `reqSigned` = 1.
- R8: A halfword on an odd address, or a word whose address is not a multiple of 4, raises `misAlign`, forces `busByteEn` to zero and produces no `loadValid`.
- R9: `loadData` and `loadValid` are registered. `loadValid` is high in the cycle after a cycle with `reqValid`, `busRdValid`, a load and no misalignment, and is low otherwise. Reset clears both.
- R10: Accesses may be issued on consecutive cycles, each with a different `bigEnd` or `styleFlip`, and each still produces its correct result with no added cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Access present this cycle |
| reqAddr | input | ADDR_W | Byte address of the access |
| reqSize | input | 2 | 0 byte, 1 halfword, 2/3 word |
| reqStore | input | 1 | 1 store, 0 load |
| reqSigned | input | 1 | Sign-extend sub-word loads |
| bigEnd | input | 1 | Big-endian order for this access |
| styleFlip | input | 1 | 0 lane-swap style, 1 address-flip style |
| storeData | input | 32 | Store operand, right-justified |
| busRdData | input | 32 | Read word returned by the bus |
| busRdValid | input | 1 | `busRdData` is valid this cycle |
| busAddr | output | ADDR_W | Word-aligned bus address |
| busByteEn | output | 4 | Byte-lane enables |
| busWrData | output | 32 | Lane-steered write data |
| misAlign | output | 1 | Access is misaligned |
| loadData | output | 32 | Aligned, extended load result |
| loadValid | output | 1 | `loadData` updated this cycle |

## Verification
The assertions assume that the request fields and `busRdData` are stable for the whole cycle in which `busRdValid` is high. They also assume that the bus returns data in the same cycle the load request is presented, so that the request fields still describe the returned word. The stimulus meets both assumptions: it drives every field once on the falling clock edge and presents a load's read word together with its request. Random addresses, including misaligned ones, are drawn across all sizes, styles and byte orders, and the order and style change from one access to the next.

// File: rtl/lsAlignPkg.sv
package lsAlignPkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;
  localparam int SEL_W  = $clog2(LANES);

  // control strobes handed from the decoder to the lane datapath
  typedef struct packed {
    logic [LANES-1:0]            laneEn;   // bus lanes touched
    logic [LANES-1:0][SEL_W-1:0] wrSel;    // per bus lane: which operand byte
    logic [LANES-1:0][SEL_W-1:0] rdSel;    // per result byte: which bus lane
    logic [LANES-1:0]            keepByte; // result byte lies inside the access
    logic [SEL_W-1:0]            signIdx;  // result byte holding the sign bit
    logic                        signExt;
    logic                        loadFire;
  } laneCtrl_t;
endpackage

// File: rtl/lsAlignCtrl.sv
module lsAlignCtrl
  import lsAlignPkg::*;
(
  input  logic             reqValid,
  input  logic [SEL_W-1:0] reqOff,
  input  logic [1:0]       reqSize,
  input  logic             reqStore,
  input  logic             reqSigned,
  input  logic             bigEnd,
  input  logic             styleFlip,
  input  logic             busRdValid,
  output laneCtrl_t        ctrl,
  output logic             misAlign
);
  logic             isWord;
  logic             isHalf;
  logic [SEL_W-1:0] lastIdx;
  logic [SEL_W-1:0] flipMask;
  logic [SEL_W-1:0] effOff;
  logic             swapOrder;

  always_comb begin
    isWord    = reqSize[1];
    isHalf    = (reqSize == 2'd1);
    lastIdx   = isWord ? SEL_W'(LANES - 1) : (isHalf ? SEL_W'(1) : SEL_W'(0));
    misAlign  = reqValid && ((isHalf && reqOff[0]) || (isWord && (reqOff != '0)));
    flipMask  = '0;
    if (styleFlip && bigEnd && !isWord)
      flipMask = isHalf ? SEL_W'(2) : SEL_W'(3);
    effOff    = reqOff ^ flipMask;
    swapOrder = bigEnd && !styleFlip;
  end

  always_comb begin
    ctrl = '0;
    for (int lane = 0; lane < LANES; lane++) begin
      logic [SEL_W-1:0] rel;
      logic [SEL_W-1:0] idx;
      idx = SEL_W'(lane);
      rel = idx - effOff;
      ctrl.laneEn[lane]   = reqValid && !misAlign && (rel <= lastIdx);
      ctrl.wrSel[lane]    = swapOrder ? (lastIdx - rel) : rel;
      ctrl.rdSel[lane]    = effOff + (swapOrder ? (lastIdx - idx) : idx);
      ctrl.keepByte[lane] = (idx <= lastIdx);
    end
    ctrl.signIdx  = lastIdx;
    ctrl.signExt  = reqSigned;
    ctrl.loadFire = reqValid && busRdValid && !reqStore && !misAlign;
  end
endmodule

// File: rtl/lsAlignData.sv
module lsAlignData
  import lsAlignPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  laneCtrl_t         ctrl,
  input  logic [DATA_W-1:0] storeData,
  input  logic [DATA_W-1:0] busRdData,
  output logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] loadData,
  output logic              loadValid
);
  logic [LANES-1:0][LANE_W-1:0] stBytes;
  logic [LANES-1:0][LANE_W-1:0] rdBytes;
  logic [LANES-1:0][LANE_W-1:0] wrBytes;
  logic [LANES-1:0][LANE_W-1:0] gathered;
  logic [LANES-1:0][LANE_W-1:0] shaped;
  logic                         fillBit;

  assign stBytes = storeData;
  assign rdBytes = busRdData;

  // one 4:1 mux per lane in each direction; mode only moves the selects
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wrBytes[g]  = stBytes[ctrl.wrSel[g]];
    assign gathered[g] = rdBytes[ctrl.rdSel[g]];
    assign shaped[g]   = ctrl.keepByte[g] ? gathered[g] : {LANE_W{fillBit}};
  end

  assign fillBit   = ctrl.signExt & gathered[ctrl.signIdx][LANE_W-1];
  assign busWrData = wrBytes;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadData  <= '0;
      loadValid <= 1'b0;
    end else begin
      loadValid <= ctrl.loadFire;
      if (ctrl.loadFire) loadData <= shaped;
    end
  end
endmodule

// File: rtl/lsAlign.sv
module lsAlign
  import lsAlignPkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              reqStore,
  input  logic              reqSigned,
  input  logic              bigEnd,
  input  logic              styleFlip,
  input  logic [DATA_W-1:0] storeData,
  input  logic [DATA_W-1:0] busRdData,
  input  logic              busRdValid,
  output logic [ADDR_W-1:0] busAddr,
  output logic [LANES-1:0]  busByteEn,
  output logic [DATA_W-1:0] busWrData,
  output logic              misAlign,
  output logic [DATA_W-1:0] loadData,
  output logic              loadValid
);
  laneCtrl_t ctrl;

  lsAlignCtrl ctrl_i (
    .reqValid  (reqValid),
    .reqOff    (reqAddr[SEL_W-1:0]),
    .reqSize   (reqSize),
    .reqStore  (reqStore),
    .reqSigned (reqSigned),
    .bigEnd    (bigEnd),
    .styleFlip (styleFlip),
    .busRdValid(busRdValid),
    .ctrl      (ctrl),
    .misAlign  (misAlign)
  );

  lsAlignData data_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .storeData(storeData),
    .busRdData(busRdData),
    .busWrData(busWrData),
    .loadData (loadData),
    .loadValid(loadValid)
  );

  assign busAddr   = {reqAddr[ADDR_W-1:SEL_W], {SEL_W{1'b0}}};
  assign busByteEn = ctrl.laneEn;
endmodule

// File: rtl/lsAlignChk.sv
module lsAlignChk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [1:0]        reqSize,
  input logic              reqStore,
  input logic              reqSigned,
  input logic              bigEnd,
  input logic              styleFlip,
  input logic              busRdValid,
  input logic [ADDR_W-1:0] busAddr,
  input logic [3:0]        busByteEn,
  input logic              misAlign,
  input logic [31:0]       loadData,
  input logic              loadValid
);
  logic fire;
  assign fire = reqValid && busRdValid && !reqStore && !misAlign;

  AST_WORD_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr[1:0] == 2'b00) && (busAddr[ADDR_W-1:2] == reqAddr[ADDR_W-1:2])); // R1
  AST_IDLE_NO_EN: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (busByteEn == 4'b0000)); // R2
  AST_EN_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !misAlign) |-> ($countones(busByteEn) ==
      (reqSize[1] ? 4 : (reqSize == 2'd1 ? 2 : 1)))); // R2
  AST_BYTE_LANE_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSize == 2'd0 && !styleFlip) |->
      (busByteEn == (4'b0001 << reqAddr[1:0]))); // R3
  AST_FLIP_BYTE_LANE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSize == 2'd0 && styleFlip && bigEnd) |->
      (busByteEn == (4'b0001 << (reqAddr[1:0] ^ 2'b11)))); // R5
  AST_MISALIGN_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    misAlign |-> (busByteEn == 4'b0000)); // R8
  AST_MISALIGN_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    misAlign |=> !loadValid); // R8
  AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    fire |=> loadValid); // R9
  AST_NO_SPURIOUS_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !fire |=> !loadValid); // R9
  AST_ZERO_EXT_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    (fire && reqSize == 2'd0 && !reqSigned) |=> (loadData[31:8] == 24'h0)); // R7
endmodule

bind lsAlign lsAlignChk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
  .reqSize(reqSize), .reqStore(reqStore), .reqSigned(reqSigned),
  .bigEnd(bigEnd), .styleFlip(styleFlip), .busRdValid(busRdValid),
  .busAddr(busAddr), .busByteEn(busByteEn), .misAlign(misAlign),
  .loadData(loadData), .loadValid(loadValid)
);

// File: tb/lsAlign_tb_top.sv
module lsAlign_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqSize = '0;
  logic        reqStore = 1'b0;
  logic        reqSigned = 1'b0;
  logic        bigEnd = 1'b0;
  logic        styleFlip = 1'b0;
  logic [31:0] storeData = '0;
  logic [31:0] busRdData = '0;
  logic        busRdValid = 1'b0;
  logic [31:0] busAddr;
  logic [3:0]  busByteEn;
  logic [31:0] busWrData;
  logic        misAlign;
  logic [31:0] loadData;
  logic        loadValid;

  lsAlign #(.ADDR_W(32)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqStore(reqStore), .reqSigned(reqSigned),
    .bigEnd(bigEnd), .styleFlip(styleFlip), .storeData(storeData),
    .busRdData(busRdData), .busRdValid(busRdValid), .busAddr(busAddr),
    .busByteEn(busByteEn), .busWrData(busWrData), .misAlign(misAlign),
    .loadData(loadData), .loadValid(loadValid)
  );

  always #4 clk = ~clk;

  int   errors = 0;
  int   checks = 0;
  bit   finished = 1'b0;
  logic [7:0] busMem [64];
  logic [7:0] refMem [64];
  bit          pendLoad = 1'b0;
  logic [31:0] pendExp = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int accLen(input logic [1:0] sz);
    return sz[1] ? 4 : (sz == 2'd1 ? 2 : 1);
  endfunction

  function automatic bit isMis(input logic [31:0] a, input logic [1:0] sz);
    return (accLen(sz) == 2 && a[0]) || (accLen(sz) == 4 && a[1:0] != 2'b00);
  endfunction

  // memory byte address holding value byte i
  function automatic logic [5:0] byteAddrOf(input logic [31:0] a, input logic [1:0] sz,
                                            input logic be, input logic fl, input int i);
    int n = accLen(sz);
    logic [5:0] base = a[5:0];
    if (fl && be && n == 1) base = base ^ 6'd3;
    if (fl && be && n == 2) base = base ^ 6'd2;
    if (!fl && be) return base + 6'(n - 1 - i);
    return base + 6'(i);
  endfunction

  task automatic step(input logic v, input logic [31:0] a, input logic [1:0] sz,
                      input logic st, input logic sg, input logic be, input logic fl,
                      input logic [31:0] d, input string tag);
    logic [3:0]  expEn;
    logic [31:0] expWr;
    logic [31:0] val;
    logic [5:0]  ba;
    logic [5:0]  wb;
    bit          mis;
    int          n;
    @(negedge clk);
    if (pendLoad) begin
      chk(loadValid === 1'b1, {"R9 loadValid ", tag}, {31'b0, loadValid}, 32'h1);
      chk(loadData === pendExp, {"R7 loadData ", tag}, loadData, pendExp);
    end else begin
      chk(loadValid === 1'b0, {"R9 no loadValid ", tag}, {31'b0, loadValid}, 32'h0);
    end
    reqValid = v; reqAddr = a; reqSize = sz; reqStore = st; reqSigned = sg;
    bigEnd = be; styleFlip = fl; storeData = d;
    n = accLen(sz);
    mis = v && isMis(a, sz);
    expEn = '0; expWr = '0; val = '0;
    if (v && !mis) begin
      for (int i = 0; i < n; i++) begin
        ba = byteAddrOf(a, sz, be, fl, i);
        expEn[ba[1:0]] = 1'b1;
        expWr[ba[1:0]*8 +: 8] = d[i*8 +: 8];
        val[i*8 +: 8] = refMem[ba];
        if (st) refMem[ba] = d[i*8 +: 8];
      end
      if (sg && val[n*8-1])
        for (int i = n; i < 4; i++) val[i*8 +: 8] = 8'hFF;
    end
    wb = {a[5:2], 2'b00};
    busRdData = {busMem[wb+3], busMem[wb+2], busMem[wb+1], busMem[wb]};
    busRdValid = v && !st;
    #1;
    chk(busAddr === {a[31:2], 2'b00}, {"R1 busAddr ", tag}, busAddr, {a[31:2], 2'b00});
    chk(misAlign === mis, {"R8 misAlign ", tag}, {31'b0, misAlign}, {31'b0, mis});
    chk(busByteEn === expEn, {"R2 R3 R4 R5 R8 byteEn ", tag}, {28'b0, busByteEn}, {28'b0, expEn});
    if (v && st && !mis) begin
      for (int l = 0; l < 4; l++)
        if (expEn[l]) begin
          chk(busWrData[l*8 +: 8] === expWr[l*8 +: 8], {"R6 wrData ", tag},
              {24'b0, busWrData[l*8 +: 8]}, {24'b0, expWr[l*8 +: 8]});
          if (busByteEn[l]) busMem[wb + 6'(l)] = busWrData[l*8 +: 8];
        end
    end else if (busByteEn !== 4'b0000 && st) begin
      for (int l = 0; l < 4; l++)
        if (busByteEn[l]) busMem[wb + 6'(l)] = busWrData[l*8 +: 8];
    end
    pendLoad = v && !st && !mis;
    pendExp  = val;
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) begin
      busMem[i] = 8'($urandom);
      refMem[i] = busMem[i];
    end
    repeat (3) @(posedge clk);
    #1;
    chk(loadValid === 1'b0, "R9 reset loadValid", {31'b0, loadValid}, 32'h0);
    chk(loadData === 32'h0, "R9 reset loadData", loadData, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    // R4: word at 0x1234 in both orders, lane-swap style
    step(1, 32'h1234, 2'd2, 1, 0, 0, 0, 32'h11223344, "R4 word le store");
    step(1, 32'h1234, 2'd0, 0, 0, 0, 0, 0, "R4 lsb at 0x1234 le");
    step(1, 32'h1234, 2'd2, 1, 0, 1, 0, 32'hA1B2C3D4, "R4 word be store");
    step(1, 32'h1237, 2'd0, 0, 0, 1, 0, 0, "R4 lsb at 0x1237 be");
    step(1, 32'h1236, 2'd1, 0, 0, 1, 0, 0, "R4 low half at 0x1236 be");
    // R3: byte access reaches the same byte in both orders
    step(1, 32'h0000_0011, 2'd0, 1, 0, 1, 0, 32'h0000_005A, "R3 byte be store");
    step(1, 32'h0000_0011, 2'd0, 0, 0, 0, 0, 0, "R3 byte le load");
    // R5: address-flip style
    step(1, 32'h0000_0020, 2'd0, 1, 0, 1, 1, 32'h0000_00C3, "R5 flip byte store");
    step(1, 32'h0000_0023, 2'd0, 0, 0, 0, 1, 0, "R5 flip byte seen at ^3");
    step(1, 32'h0000_0022, 2'd1, 1, 0, 1, 1, 32'h0000_BEEF, "R5 flip half store");
    step(1, 32'h0000_0020, 2'd1, 0, 0, 0, 0, 0, "R5 flip half seen at ^2");
    step(1, 32'h0000_0024, 2'd3, 1, 0, 1, 1, 32'h0BAD_F00D, "R5 flip word unchanged");
    // R7: sign extension corners
    step(1, 32'h0000_0030, 2'd1, 1, 0, 0, 0, 32'h0000_8001, "R7 half store");
    step(1, 32'h0000_0030, 2'd1, 0, 1, 0, 0, 0, "R7 signed half");
    step(1, 32'h0000_0030, 2'd1, 0, 0, 0, 0, 0, "R7 unsigned half");
    step(1, 32'h0000_0031, 2'd0, 0, 1, 0, 0, 0, "R7 signed byte");
    // R8: misaligned
    step(1, 32'h0000_0033, 2'd1, 1, 0, 0, 0, 32'hFFFF_FFFF, "R8 odd half store");
    step(1, 32'h0000_0032, 2'd2, 0, 0, 1, 0, 0, "R8 word at +2 load");
    step(0, 32'h0000_0030, 2'd2, 1, 0, 0, 0, 32'h1, "R2 idle");
    // R10: back-to-back loads alternating order and style
    for (int k = 0; k < 8; k++)
      step(1, 32'h0000_0010 + 32'(k), 2'd0, 0, k[0], k[1], k[2], 0, "R10 byte burst");
    for (int k = 0; k < 4; k++)
      step(1, 32'h0000_0008, 2'd2, 0, 0, k[0], k[1], 0, "R10 word burst");

    // random mix
    for (int k = 0; k < 1500; k++) begin
      logic [31:0] ra;
      logic [1:0]  rs;
      ra = $urandom;
      rs = 2'($urandom);
      if ($urandom_range(3) != 0) begin
        if (accLen(rs) == 2) ra[0] = 1'b0;
        if (accLen(rs) == 4) ra[1:0] = 2'b00;
      end
      step($urandom_range(7) != 0, ra, rs, 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), $urandom, "random");
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, "flush");

    for (int i = 0; i < 64; i++)
      chk(busMem[i] === refMem[i], "R6 final memory image", {24'b0, busMem[i]}, {24'b0, refMem[i]});
    summary();
  end
endmodule